// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Status Readback

This block is a two-wire serial (I2C) slave that gives a host write access to a bank of 47 eight-bit control registers, at subaddresses 0x00 to 0x2E. It also gives read access to three read-only status bytes that are supplied from outside the block. The block samples SCL and SDA from the system clock domain and detects START and STOP. It matches the 7-bit device address and acknowledges the bytes it accepts. On reads it shifts status data out on SDA through an open-drain pull-down enable.

A write transfer sends the address byte, then one subaddress byte, then any number of data bytes. After each data byte the target subaddress moves up by one, so a single transfer can load a run of registers. A read transfer has no subaddress phase. It always starts at status byte 0 and continues through the status bytes for as long as the master acknowledges. The register contents are exported in parallel, together with a one-cycle strobe per register that marks each byte written.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset all registers read 0x00, no write strobe is active and SDA is not driven.
- R2: The device address is 7'h45. The byte 0x8A (write) and the byte 0x8B (read) are acknowledged. Any other address byte gets no acknowledge, and no byte of that frame is acknowledged or written.
- R3: In a write frame, the byte after the address byte sets the subaddress and is acknowledged. Each following data byte is acknowledged and stored in register `sub`, which appears on `regs_o[8*sub+7 : 8*sub]`.
- R4: After each data byte the subaddress advances by one, so consecutive data bytes in one frame land in consecutive registers.
- R5: A data byte whose subaddress is above 0x2E is acknowledged but changes no register and raises no strobe. The subaddress never wraps back to 0x00.
- R6: A read frame returns status byte 0 (`status_i[7:0]`) first, with no subaddress phase. While the master acknowledges, it then returns byte 1 (`status_i[15:8]`) and byte 2 (`status_i[23:16]`). Each byte is sent MSB first, and each new read frame starts again at byte 0.
- R7: After the master NACKs a read byte, the slave releases SDA and sends nothing more until the next START.
- R8: If the master keeps acknowledging past status byte 2, every further byte reads 0xFF.
- R9: A repeated START, with no STOP before it, restarts the frame at the address byte, for both read and write.
- R10: Each stored data byte raises exactly one bit of `wr_stb_o`, bit `sub`, for exactly one clock cycle.
- R11: The slave changes its SDA pull-down only while SCL is low.
- R12: A STOP that arrives part-way through a data byte ends the frame without writing any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are sampled in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| status_i | input | 24 | Three status bytes; byte k is on bits 8k+7:8k |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | 376 | Register contents; register i is on bits 8i+7:8i |
| wr_stb_o | output | 47 | One-cycle write strobe; bit i means register i was written |

## Verification
The assertions assume that SCL and SDA each stay at one level for several system clocks between edges. This lets the synchronizer and edge detector see every transition, and lets the slave's SDA update land while SCL is still low. The assertions also assume that the master never makes a START or STOP while the slave is driving an acknowledge or a zero data bit. The stimulus holds each SCL quarter-phase for ten clock cycles. It changes SDA only while SCL is low, except on purpose for START and STOP, and it releases SDA in every acknowledge and read-data slot that belongs to the slave.

// File: rtl/i2c_regbank_pkg.sv
// Shared types for the two-wire register slave.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package i2c_regbank_pkg;

    // Where the frame engine is within a byte transfer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_t;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        BY_ADDR,
        BY_SUB,
        BY_DATA
    } byte_kind_t;

    // Bus events decoded from the synchronised lines
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA into the clock domain and decodes START, STOP
// and the SCL edges from them.
// Assumes: each bus level is held for more than STAGES+1 clock cycles.
module i2c_line_sync
    import i2c_regbank_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev,
    output logic    scl_lvl
);

    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;
    logic            scl_s, scl_p, sda_s, sda_p;

    // Shift the raw lines through the synchroniser and one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign scl_p = scl_q[STAGES];
    assign sda_s = sda_q[STAGES-1];
    assign sda_p = sda_q[STAGES];

    // Decode the bus conditions from the current and previous samples
    always_comb begin
        ev.start = scl_s && scl_p && sda_p && !sda_s;
        ev.stop  = scl_s && scl_p && !sda_p && sda_s;
        ev.rise  = scl_s && !scl_p;
        ev.fall  = !scl_s && scl_p;
        ev.sda   = sda_s;
    end

    assign scl_lvl = scl_s;

endmodule

// File: rtl/i2c_frame_engine.sv
// Byte-phase state machine: matches the address, collects the subaddress and
// data bytes of write frames, and serialises the status bytes of read frames.
// Assumes: bus events come from i2c_line_sync; the master obeys bus timing.
module i2c_frame_engine
    import i2c_regbank_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h45,
    parameter int         NREG     = 47,
    parameter int         NSTAT    = 3,
    parameter int         SUB_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bus_ev_t            ev,
    input  logic               scl_lvl,
    input  logic [NSTAT*8-1:0] status_i,
    output logic               sda_oe,
    output logic               wr_en,
    output logic [SUB_W-1:0]   wr_sub,
    output logic [7:0]         wr_data
);

    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(NREG - 1);
    localparam int               IDX_W    = $clog2(NSTAT + 1);

    phase_t           state;
    byte_kind_t       kind;
    logic [3:0]       cnt;
    logic [7:0]       sh;
    logic [7:0]       tx;
    logic [SUB_W-1:0] sub;
    logic             rw;
    logic             mack;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] rd_sel;
    logic [7:0]       stat_byte;

    // Pick the index and value of the next status byte to send (0xFF past the end)
    always_comb begin
        if (state == PH_ACK)
            rd_sel = '0;
        else if (int'(rd_idx) >= NSTAT)
            rd_sel = rd_idx;
        else
            rd_sel = rd_idx + 1'b1;
        stat_byte = 8'hFF;
        for (int k = 0; k < NSTAT; k++)
            if (int'(rd_sel) == k) stat_byte = status_i[k*8 +: 8];
    end

    // Advance the frame on START/STOP and SCL edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PH_IDLE;
            kind    <= BY_ADDR;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '1;
            sub     <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            rd_idx  <= '0;
            wr_en   <= 1'b0;
            wr_sub  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                state <= PH_RX;
                kind  <= BY_ADDR;
                cnt   <= '0;
            end else if (ev.stop) begin
                state <= PH_IDLE;
            end else begin
                case (state)
                    PH_RX: begin
                        if (ev.rise) begin
                            sh  <= {sh[6:0], ev.sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev.fall && cnt == 4'd8) begin
                            cnt <= '0;
                            case (kind)
                                BY_ADDR: begin
                                    if (sh[7:1] == DEV_ADDR) begin
                                        rw    <= sh[0];
                                        state <= PH_ACK;
                                    end else begin
                                        state <= PH_IDLE;
                                    end
                                end
                                BY_SUB: begin
                                    sub   <= SUB_W'(sh);
                                    state <= PH_ACK;
                                end
                                default: begin
                                    state <= PH_ACK;
                                    if (sub <= LAST_SUB) begin
                                        wr_en   <= 1'b1;
                                        wr_sub  <= sub;
                                        wr_data <= sh;
                                        sub     <= sub + 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                    PH_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            if (kind == BY_ADDR && rw) begin
                                state  <= PH_TX;
                                tx     <= stat_byte;
                                rd_idx <= rd_sel;
                            end else begin
                                state <= PH_RX;
                                kind  <= (kind == BY_ADDR) ? BY_SUB : BY_DATA;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.fall) begin
                            tx <= {tx[6:0], 1'b1};
                            if (cnt == 4'd7) begin
                                cnt   <= '0;
                                state <= PH_MACK;
                            end else begin
                                cnt <= cnt + 4'd1;
                            end
                        end
                    end
                    PH_MACK: begin
                        if (ev.rise) begin
                            mack <= !ev.sda;
                        end else if (ev.fall) begin
                            if (mack) begin
                                state  <= PH_TX;
                                tx     <= stat_byte;
                                rd_idx <= rd_sel;
                            end else begin
                                state <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Pull SDA low for acknowledges and for zero bits of transmitted data
    assign sda_oe = (state == PH_ACK) || (state == PH_TX && !tx[7]);

    // R11: the pull-down only moves while the synchronised SCL is low
    p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R6: transmission of a byte only begins from an acknowledge slot
    p_tx_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_TX && $past(state) != PH_TX) |->
        ($past(state) == PH_ACK || $past(state) == PH_MACK));

endmodule

// File: rtl/i2c_reg_bank.sv
// Holds the control registers, decodes the write subaddress into a one-hot
// strobe and exports the contents flat.
// Assumes: wr_en is a single-cycle pulse from the frame engine.
module i2c_reg_bank #(
    parameter int NREG  = 47,
    parameter int SUB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SUB_W-1:0]  wr_sub,
    input  logic [7:0]        wr_data,
    output logic [NREG*8-1:0] regs_o,
    output logic [NREG-1:0]   wr_stb_o
);

    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(NREG - 1);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [7:0] q;

        // Decode this register's strobe
        assign wr_stb_o[i] = wr_en && (wr_sub == SUB_W'(i));

        // Load the register on its strobe
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else if (wr_stb_o[i]) q <= wr_data;
        end

        assign regs_o[i*8 +: 8] = q;

        // R3: a strobed register holds the written byte on the next cycle
        p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb_o[i] |=> (q == $past(wr_data)));
    end

    // R10: at most one register is written per cycle
    p_stb_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_o));

    // R10: a strobe lasts one cycle only
    p_stb_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb_o) |=> !(|wr_stb_o));

    // R5: the engine never requests a write beyond the last register
    p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_sub <= LAST_SUB));

endmodule

// File: rtl/i2c_regbank_slave.sv
// Top level: a two-wire slave that loads a bank of control registers with
// auto-incrementing subaddress and returns status bytes on reads.
// Assumes: pads are open-drain; sda_oe_o high means SDA is pulled low.
module i2c_regbank_slave
    import i2c_regbank_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h45,
    parameter int         NREG        = 47,
    parameter int         NSTAT       = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [NSTAT*8-1:0] status_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] regs_o,
    output logic [NREG-1:0]   wr_stb_o
);

    localparam int SUB_W = 8;

    bus_ev_t          ev;
    logic             scl_lvl;
    logic             wr_en;
    logic [SUB_W-1:0] wr_sub;
    logic [7:0]       wr_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .ev      (ev),
        .scl_lvl (scl_lvl)
    );

    i2c_frame_engine #(
        .DEV_ADDR (DEV_ADDR),
        .NREG     (NREG),
        .NSTAT    (NSTAT),
        .SUB_W    (SUB_W)
    ) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .scl_lvl  (scl_lvl),
        .status_i (status_i),
        .sda_oe   (sda_oe_o),
        .wr_en    (wr_en),
        .wr_sub   (wr_sub),
        .wr_data  (wr_data)
    );

    i2c_reg_bank #(
        .NREG  (NREG),
        .SUB_W (SUB_W)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sub   (wr_sub),
        .wr_data  (wr_data),
        .regs_o   (regs_o),
        .wr_stb_o (wr_stb_o)
    );

endmodule

// File: tb/test_i2c_regbank_slave.sv
// Self-checking bench: a bit-banged bus master drives frames, a bench model
// predicts register contents, and outputs are compared at the ports.
module test_i2c_regbank_slave;

    localparam int NREG  = 47;
    localparam int NSTAT = 3;
    localparam int Q     = 10;

    // Write bursts: {subaddress, first byte, second byte}
    localparam logic [23:0] VEC [6] = '{
        {8'h00, 8'hA5, 8'h3C},
        {8'h10, 8'h01, 8'hFE},
        {8'h1F, 8'h80, 8'h7F},
        {8'h20, 8'h55, 8'hAA},
        {8'h2C, 8'h12, 8'h34},
        {8'h08, 8'hC0, 8'h0D}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                scl_m = 1'b1;
    logic                sda_m = 1'b1;
    logic                sda_line;
    logic [NSTAT*8-1:0]  status;
    logic                sda_oe_o;
    logic [NREG*8-1:0]   regs_o;
    logic [NREG-1:0]     wr_stb_o;

    int nchk = 0;
    int nfail = 0;
    int stb_cnt = 0;
    int viol = 0;
    logic oe_prev = 1'b0;
    logic [7:0] mdl [NREG];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe_o;

    i2c_regbank_slave i_i2c_regbank_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .status_i (status),
        .sda_oe_o (sda_oe_o),
        .regs_o   (regs_o),
        .wr_stb_o (wr_stb_o)
    );

    // Count strobe cycles and pull-down moves while the bench holds SCL high
    always @(negedge clk) begin
        if (|wr_stb_o) stb_cnt++;
        if (rst_n && sda_oe_o != oe_prev && scl_m) viol++;
        oe_prev <= sda_oe_o;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input int i);
        return regs_o[i*8 +: 8];
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            d = {d[6:0], sda_line}; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        send_bit(!give_ack);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int s0;
        logic anyset;
        status = {8'h3C, 8'h96, 8'hE1};
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        anyset = |regs_o;
        chk("R1 regs zero", {31'd0, anyset}, 32'd0);
        chk("R1 sda released", {31'd0, sda_oe_o}, 32'd0);
        chk("R1 no strobe", stb_cnt, 0);

        // R3/R4/R10: table of two-byte write bursts
        for (int v = 0; v < 6; v++) begin
            logic [7:0] sub, b0, b1;
            {sub, b0, b1} = VEC[v];
            s0 = stb_cnt;
            bus_start();
            send_byte(8'h8A, ack); chk("R2 write address ack", {31'd0, ack}, 32'd1);
            send_byte(sub, ack);   chk("R3 subaddress ack", {31'd0, ack}, 32'd1);
            send_byte(b0, ack);    chk("R3 data ack", {31'd0, ack}, 32'd1);
            send_byte(b1, ack);    chk("R4 second data ack", {31'd0, ack}, 32'd1);
            bus_stop();
            tick(2);
            mdl[sub] = b0;
            mdl[sub + 8'd1] = b1;
            chk("R3 first byte stored", reg_at(int'(sub)), b0);
            chk("R4 next register stored", reg_at(int'(sub) + 1), b1);
            chk("R10 one strobe per byte", stb_cnt - s0, 2);
        end

        // R5: bytes past the last register are acked and dropped, no wrap
        s0 = stb_cnt;
        bus_start();
        send_byte(8'h8A, ack);
        send_byte(8'h2D, ack);
        send_byte(8'h77, ack);
        send_byte(8'h88, ack);
        send_byte(8'h99, ack); chk("R5 out of range ack", {31'd0, ack}, 32'd1);
        send_byte(8'h66, ack); chk("R5 out of range ack again", {31'd0, ack}, 32'd1);
        bus_stop();
        tick(2);
        mdl[8'h2D] = 8'h77;
        mdl[8'h2E] = 8'h88;
        chk("R4 reg 2D", reg_at(8'h2D), 8'h77);
        chk("R5 reg 2E keeps in-range byte", reg_at(8'h2E), 8'h88);
        chk("R5 no wrap to reg 00", reg_at(0), mdl[0]);
        chk("R5 no wrap to reg 01", reg_at(1), mdl[1]);
        chk("R5 strobes only in range", stb_cnt - s0, 2);

        s0 = stb_cnt;
        bus_start();
        send_byte(8'h8A, ack);
        send_byte(8'h30, ack);
        send_byte(8'h55, ack); chk("R5 high subaddress ack", {31'd0, ack}, 32'd1);
        bus_stop();
        tick(2);
        chk("R5 high subaddress no strobe", stb_cnt - s0, 0);

        // R2: foreign address is ignored for the whole frame
        s0 = stb_cnt;
        bus_start();
        send_byte(8'h90, ack); chk("R2 foreign address nack", {31'd0, ack}, 32'd0);
        send_byte(8'h01, ack); chk("R2 foreign frame nack", {31'd0, ack}, 32'd0);
        send_byte(8'h42, ack); chk("R2 foreign data nack", {31'd0, ack}, 32'd0);
        bus_stop();
        tick(2);
        chk("R2 foreign frame no write", reg_at(1), mdl[1]);
        chk("R2 foreign frame no strobe", stb_cnt - s0, 0);

        // R6/R8: status bytes in order, then 0xFF
        bus_start();
        send_byte(8'h8B, ack); chk("R2 read address ack", {31'd0, ack}, 32'd1);
        read_byte(1'b1, d); chk("R6 status 0", d, 8'hE1);
        read_byte(1'b1, d); chk("R6 status 1", d, 8'h96);
        read_byte(1'b1, d); chk("R6 status 2", d, 8'h3C);
        read_byte(1'b1, d); chk("R8 past end", d, 8'hFF);
        read_byte(1'b0, d); chk("R8 past end again", d, 8'hFF);
        bus_stop();

        // R6/R7: new read restarts at byte 0; nothing is sent after the NACK
        status = {8'h3C, 8'h96, 8'h4B};
        bus_start();
        send_byte(8'h8B, ack);
        read_byte(1'b0, d); chk("R6 restart at status 0", d, 8'h4B);
        chk("R7 released after nack", {31'd0, sda_oe_o}, 32'd0);
        read_byte(1'b0, d); chk("R7 silent after nack", d, 8'hFF);
        bus_stop();

        // R9: repeated START into a read
        bus_start();
        send_byte(8'h8A, ack);
        send_byte(8'h05, ack);
        send_byte(8'h11, ack);
        bus_start();
        send_byte(8'h8B, ack); chk("R9 read after repeated start", {31'd0, ack}, 32'd1);
        read_byte(1'b0, d); chk("R9 status 0 after repeated start", d, 8'h4B);
        bus_stop();
        tick(2);
        mdl[5] = 8'h11;
        chk("R9 write before repeated start", reg_at(5), 8'h11);

        // R9: repeated START into a new write frame
        bus_start();
        send_byte(8'h8A, ack);
        send_byte(8'h06, ack);
        bus_start();
        send_byte(8'h8A, ack);
        send_byte(8'h07, ack);
        send_byte(8'h22, ack);
        bus_stop();
        tick(2);
        mdl[7] = 8'h22;
        chk("R9 new subaddress used", reg_at(7), 8'h22);
        chk("R9 old subaddress untouched", reg_at(6), mdl[6]);

        // R12: STOP in the middle of a data byte
        s0 = stb_cnt;
        bus_start();
        send_byte(8'h8A, ack);
        send_byte(8'h09, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        tick(2);
        chk("R12 aborted byte not written", reg_at(9), mdl[9]);
        chk("R12 aborted byte no strobe", stb_cnt - s0, 0);

        // R3: the whole bank matches the model
        anyset = 1'b0;
        for (int i = 0; i < NREG; i++) if (reg_at(i) != mdl[i]) anyset = 1'b1;
        chk("R3 full bank matches model", {31'd0, anyset}, 32'd0);

        // R11: pull-down never moved while SCL was high
        chk("R11 sda moves only with scl low", viol, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule